// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Mode Detection

This block is the digital serial side of an 8-bit voice codec channel. On the transmit side it takes a parallel code word, holds it for one frame, and shifts it out MSB first on a data line that carries a separate output enable, so a pad can tri-state it. On the receive side it gathers eight serial bits into a byte and hands it out with a one-cycle strobe. Companding and analog conversion sit elsewhere.

Two framing conventions are served by the same pins. A one-bit-wide sync (short) marks the frame one bit clock ahead of the sign bit. A sync three or more bit clocks wide (long) coincides with the sign bit. The block measures each transmit sync pulse and switches convention by itself; the receive side follows the same decision. In synchronous operation the receive side runs from the transmit bit clock and the receive bit clock pin is ignored.

All logic runs on one fast system clock. Bit clocks and syncs are slow inputs sampled on it, and their edges are found by comparison with the previous sample.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset `tx_oe`, `tx_sd`, `rx_valid` and `long_sync` are 0 and `rx_word` is 0x00.
- R2: The sync width is the number of `tx_bclk` falling edges at which `tx_fs` is high during one pulse; when `tx_fs` falls, a width of 1 sets `long_sync` to 0 (short), a width of 3 or more sets it to 1 (long), and a width of 2 leaves it unchanged.
- R3: In short mode, `tx_fs` high at a `tx_bclk` falling edge makes the next `tx_bclk` rising edge raise `tx_oe` with the word's bit 7 on `tx_sd`; each of the next seven rising edges moves to the next lower bit.
- R4: In short mode `tx_oe` drops at the `tx_bclk` falling edge that follows the eighth bit, whatever `tx_fs` does.
- R5: In long mode `tx_oe` rises with bit 7 at the later of the `tx_fs` rising edge and a `tx_bclk` rising edge (at once if `tx_bclk` is already high when `tx_fs` rises).
- R6: In long mode `tx_oe` drops at the later of the `tx_bclk` falling edge after the eighth bit and `tx_fs` going low.
- R7: Each frame start loads `tx_word` into a holding register and sends the word the holding register held before, so a frame carries the word presented at the previous frame start (0x00 for the first frame after reset).
- R8: In short mode, `rx_fs` high at a receive bit clock falling edge makes the next eight falling edges capture `rx_sd`, first bit as bit 7.
- R9: In long mode, an `rx_fs` rising edge makes the next eight receive bit clock falling edges capture `rx_sd`, first bit as bit 7.
- R10: With `sync_mode` = 1 the receive bit clock is `tx_bclk` and `rx_bclk` has no effect; with `sync_mode` = 0 it is `rx_bclk`.
- R11: After the eighth captured bit `rx_word` shows the byte and `rx_valid` is high for exactly one clock cycle.
- R12: `tx_sd` is 0 whenever `tx_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clocks |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode | input | 1 | 1: receive side uses the transmit bit clock |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Parallel word for the transmit holding register |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for the transmit data pad |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fs | input | 1 | Receive frame sync |
| rx_sd | input | 1 | Serial receive data |
| rx_word | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe with a new byte |
| long_sync | output | 1 | Detected frame sync mode, 1 = long |

## Verification
The assertions assume that bit clocks and syncs are already synchronous to `clk` and stay at each level for at least two `clk` cycles, so that every bit clock edge is seen once and an output change can be traced to the input values one and two cycles earlier. They also assume syncs are low while reset is applied. The stimulus changes every slow input on the falling edge of `clk`, holds each bit clock phase for four cycles, and places sync edges only in the middle of a phase or together with a rising bit clock edge, which keeps every frame within those assumptions.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              tx_bclk,
  input  logic              tx_fs,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_sd,
  output logic              tx_oe,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_sd,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              long_sync
);
  localparam int WC_W = $clog2(LONG_MIN + 1);
  localparam int NS_W = $clog2(WORD_W + 1);
  localparam int RC_W = $clog2(WORD_W);

  logic txb_q, fs_q, rb_q, rfs_q;
  logic rb_clk;
  assign rb_clk = sync_mode ? tx_bclk : rx_bclk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {txb_q, fs_q, rb_q, rfs_q} <= '0;
    else        {txb_q, fs_q, rb_q, rfs_q} <= {tx_bclk, tx_fs, rb_clk, rx_fs};

  logic txb_rise, txb_fall, fs_rise, fs_fall, rb_fall, rfs_rise;
  assign txb_rise = tx_bclk & ~txb_q;
  assign txb_fall = ~tx_bclk & txb_q;
  assign fs_rise  = tx_fs & ~fs_q;
  assign fs_fall  = ~tx_fs & fs_q;
  assign rb_fall  = ~rb_clk & rb_q;
  assign rfs_rise = rx_fs & ~rfs_q;

  // sync width measurement, applied when the pulse ends
  logic [WC_W-1:0] wcnt;
  logic            long_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt   <= '0;
      long_q <= 1'b0;
    end else if (fs_fall) begin
      if (wcnt == WC_W'(1))             long_q <= 1'b0;
      else if (wcnt >= WC_W'(LONG_MIN)) long_q <= 1'b1;
      wcnt <= '0;
    end else if (txb_fall && tx_fs && wcnt < WC_W'(LONG_MIN)) begin
      wcnt <= wcnt + 1'b1;
    end

  assign long_sync = long_q;

  // transmit path
  logic              active, armed, pend, tail_fell;
  logic [NS_W-1:0]   nsent;
  logic [WORD_W-1:0] sh, hold;
  logic tail, fall8, tx_end, start_s, start_l, tx_start, arm_set;

  assign tail     = nsent == NS_W'(WORD_W);
  assign fall8    = tail_fell | (tail & txb_fall);
  assign tx_end   = active & fall8 & (~long_q | ~tx_fs);
  assign start_s  = ~long_q & armed & txb_rise;
  assign start_l  = long_q & ~active & ((fs_rise & tx_bclk) | (pend & txb_rise));
  assign tx_start = start_s | start_l;
  assign arm_set  = ~long_q & txb_fall & tx_fs & (~active | tx_end);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (arm_set)                 armed <= 1'b1;
      else if (tx_start || long_q) armed <= 1'b0;
      if (tx_start || fs_fall || !long_q)              pend <= 1'b0;
      else if (fs_rise && !tx_bclk && !active)         pend <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active    <= 1'b0;
      tail_fell <= 1'b0;
      nsent     <= '0;
      sh        <= '0;
      hold      <= '0;
    end else if (tx_start) begin
      active    <= 1'b1;
      tail_fell <= 1'b0;
      nsent     <= NS_W'(1);
      sh        <= hold;
      hold      <= tx_word;
    end else if (tx_end) begin
      active    <= 1'b0;
      tail_fell <= 1'b0;
    end else if (active) begin
      if (txb_rise && !tail) begin
        sh    <= sh << 1;
        nsent <= nsent + 1'b1;
      end
      if (tail && txb_fall) tail_fell <= 1'b1;
    end

  assign tx_oe = active;
  assign tx_sd = active & sh[WORD_W-1];

  // receive path
  logic              ract, rlast, rstart;
  logic [RC_W-1:0]   rcnt;
  logic [WORD_W-1:0] rsh;

  assign rlast  = ract & rb_fall & (rcnt == RC_W'(WORD_W - 1));
  assign rstart = long_q ? (rfs_rise & ~ract) : (rb_fall & rx_fs & (~ract | rlast));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ract     <= 1'b0;
      rcnt     <= '0;
      rsh      <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (ract && rb_fall) begin
        rsh  <= {rsh[WORD_W-2:0], rx_sd};
        rcnt <= rcnt + 1'b1;
        if (rlast) begin
          rx_word  <= {rsh[WORD_W-2:0], rx_sd};
          rx_valid <= 1'b1;
          ract     <= 1'b0;
        end
      end
      if (rstart) begin
        ract <= 1'b1;
        rcnt <= '0;
      end
    end
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_mode,
  input logic tx_bclk,
  input logic tx_fs,
  input logic rx_bclk,
  input logic tx_oe,
  input logic rx_valid,
  input logic long_sync
);
  assert_oe_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(tx_bclk));

  assert_oe_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> (!$past(tx_bclk) || !$past(tx_fs)));

  assert_mode_at_sync_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (long_sync != $past(long_sync)) |-> (!$past(tx_fs) && $past(tx_fs, 2)));

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_strobe_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(sync_mode) ? !$past(tx_bclk) : !$past(rx_bclk)));
endmodule

bind pcm_serial_port pcm_serial_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tx_bclk(tx_bclk),
  .tx_fs(tx_fs), .rx_bclk(rx_bclk), .tx_oe(tx_oe), .rx_valid(rx_valid),
  .long_sync(long_sync)
);

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n, sync_mode, tx_bclk, tx_fs, rx_bclk, rx_fs, rx_sd;
  logic [7:0] tx_word, rx_word;
  logic tx_sd, tx_oe, rx_valid, long_sync;

  pcm_serial_port uut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .tx_bclk(tx_bclk),
    .tx_fs(tx_fs), .tx_word(tx_word), .tx_sd(tx_sd), .tx_oe(tx_oe),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_sd(rx_sd), .rx_word(rx_word),
    .rx_valid(rx_valid), .long_sync(long_sync)
  );

  int checks = 0, errors = 0;
  logic [7:0] txq[$], rxq[$];
  logic [7:0] prev_word = 8'h00;
  bit skip = 0;

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  // monitor: collects transmitted bits at bit clock falls, compares bytes
  logic prev_b = 0, prev_oe = 0, prev_v = 0;
  logic [7:0] mbyte = 0;
  int mbits = 0;
  always @(negedge clk) begin
    #1;
    if (prev_b && !tx_bclk && tx_oe) begin
      if (mbits < 8) mbyte = {mbyte[6:0], tx_sd};
      mbits++;
    end
    if (prev_oe && !tx_oe) begin
      if (!skip) begin
        if (txq.size() == 0) chk(0, "R7 unexpected transmit frame", {24'h0, mbyte}, 0);
        else begin
          logic [7:0] e;
          e = txq.pop_front();
          chk(mbyte == e && mbits >= 8, "R3 R5 R7 transmitted word", {24'h0, mbyte}, {24'h0, e});
        end
      end
      mbits = 0;
    end
    if (rx_valid) begin
      chk(!prev_v, "R11 strobe longer than one cycle", 1, 0);
      if (!skip) begin
        if (rxq.size() == 0) chk(0, "R11 unexpected receive strobe", {24'h0, rx_word}, 0);
        else begin
          logic [7:0] e;
          e = rxq.pop_front();
          chk(rx_word == e, "R8 R9 R10 R11 received byte", {24'h0, rx_word}, {24'h0, e});
        end
      end
    end
    prev_b = tx_bclk; prev_oe = tx_oe; prev_v = rx_valid;
  end

  // driver: one frame, times in system clock ticks from the first bit clock rise
  task automatic frame(int fs_on, int fs_off, int rfs_on, int rfs_off, int en, int dis,
                       int ncyc, bit drv_tx, bit drv_rx, bit junk, logic [7:0] word,
                       logic [7:0] rbyte, bit skp, string tag);
    int bad = 0;
    logic first_act = 0, first_exp = 0;
    skip = skp;
    tx_word = word;
    if (!skp) begin
      if (en < 1000) txq.push_back(prev_word);
      if (rfs_on < rfs_off) rxq.push_back(rbyte);
    end
    if (en < 1000) prev_word = word;
    for (int g = 0; g <= ncyc * 8; g++) begin
      logic b;
      logic exp;
      @(negedge clk);
      b = (g % 8) < 4 && g < ncyc * 8;
      tx_bclk = drv_tx ? b : 1'b0;
      rx_bclk = drv_rx ? b : (junk ? ((g / 3) % 2 == 1) : 1'b0);
      tx_fs = g >= fs_on && g < fs_off;
      rx_fs = g >= rfs_on && g < rfs_off;
      if (g % 8 == 0 && g / 8 >= 1 && g / 8 <= 8) rx_sd = rbyte[8 - g / 8];
      if (g > 0) begin
        exp = (g - 1 >= en) && (g - 1 < dis);
        if (tx_oe !== exp || (!tx_oe && tx_sd !== 1'b0)) begin
          if (bad == 0) begin first_act = tx_oe; first_exp = exp; end
          bad++;
        end
      end
    end
    chk(bad == 0, {tag, " R12 enable window"}, {31'h0, first_act}, {31'h0, first_exp});
    repeat (6) @(negedge clk);
    if (!skp) chk(txq.size() == 0 && rxq.size() == 0, {tag, " R7 R11 all items delivered"},
                  txq.size() + rxq.size(), 0);
    skip = 0;
  endtask

  initial begin
    rst_n = 0; sync_mode = 1; tx_bclk = 0; tx_fs = 0; rx_bclk = 0; rx_fs = 0;
    rx_sd = 0; tx_word = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_oe == 0 && tx_sd == 0, "R1 transmit idle after reset", {tx_oe, tx_sd}, 0);
    chk(rx_valid == 0 && rx_word == 0, "R1 receive idle after reset", {rx_valid, rx_word}, 0);
    chk(long_sync == 0, "R1 short mode after reset", long_sync, 0);

    frame(0, 8, 0, 8, 8, 68, 10, 1, 0, 0, 8'hA5, 8'h3C, 0, "R3 R4 R8 short first");
    chk(long_sync == 0, "R2 width one keeps short", long_sync, 0);
    frame(0, 8, 0, 8, 8, 68, 10, 1, 0, 0, 8'h5A, 8'hC3, 0, "R3 R4 R8 short second");
    frame(0, 8, 0, 8, 8, 68, 10, 1, 0, 1, 8'h81, 8'h96, 0, "R10 synchronous, receive clock ignored");
    sync_mode = 0;
    frame(0, 0, 0, 8, 1000, 1000, 10, 0, 1, 0, 8'h77, 8'h71, 0, "R10 separate receive clock");
    sync_mode = 1;
    frame(6, 22, 0, 0, 16, 76, 12, 1, 0, 0, 8'h42, 8'h00, 1, "R2 width two in short");
    chk(long_sync == 0, "R2 width two leaves short unchanged", long_sync, 0);
    frame(6, 30, 0, 0, 16, 76, 12, 1, 0, 0, 8'h18, 8'h00, 1, "R2 R4 first long pulse");
    chk(long_sync == 1, "R2 width three selects long", long_sync, 1);
    frame(6, 30, 6, 30, 8, 68, 10, 1, 0, 0, 8'hE7, 8'h0F, 0, "R5 R6 R9 long, sync rises while clock low");
    frame(10, 34, 10, 34, 10, 68, 10, 1, 0, 0, 8'h66, 8'hF0, 0, "R5 R6 R9 long, sync rises while clock high");
    frame(6, 90, 6, 90, 8, 90, 13, 1, 0, 0, 8'h99, 8'h55, 0, "R6 long, sync held past eighth bit");
    frame(6, 22, 0, 0, 8, 68, 10, 1, 0, 0, 8'h24, 8'h00, 1, "R2 width two in long");
    chk(long_sync == 1, "R2 width two leaves long unchanged", long_sync, 1);
    frame(0, 8, 0, 0, 0, 60, 10, 1, 0, 0, 8'hC3, 8'h00, 1, "R2 R5 short pulse in long mode");
    chk(long_sync == 0, "R2 width one returns to short", long_sync, 0);
    frame(0, 8, 0, 8, 8, 68, 10, 1, 0, 0, 8'h3E, 8'hAA, 0, "R3 R4 R7 R8 short after long");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule